// File: doc/BRIEF.md
# Open-Page DRAM Read Command Scheduler

This block turns a stream of read requests for one DRAM bank into a per-cycle command sequence. Each request carries a row and a column. The block remembers which row is open in the bank. A request to that row goes straight to a read. A request to any other row first closes the open page, waits out the precharge delay, opens the new row and waits out the activate-to-read delay before it reads. The very first request after reset finds no open page, so it only opens a row and then reads.

Every read returns a burst of eight double-rate transfers, which keeps the data bus busy for four clock cycles. Data appears a CAS-latency number of cycles after the read command. When a same-row request is waiting, the block places the next read exactly four cycles after the previous one. That is CAS-latency cycles before the running burst ends, so consecutive bursts in one page run with no gap at any CAS latency. A data-valid strobe marks the cycles in which burst data is on the bus. CAS latency, precharge delay and activate-to-read delay are inputs, and may change only while the block is idle.

Top module: `open_page_rd_sched`

## Requirements
- R1: After a synchronous active-low reset, no row is open, the command is NOP with zero row and column, data_valid is low and req_ready is high.
- R2: The first request after reset issues ACTIVATE for its row on the cycle after acceptance and no PRECHARGE. The READ follows exactly cfg_trcd cycles after the ACTIVATE.
- R3: A request whose row equals the open row issues READ with that row and column on the cycle after acceptance. This holds for columns in any order, ascending or descending.
- R4: A request to another row issues PRECHARGE carrying the old row on the cycle after acceptance. ACTIVATE of the new row follows exactly cfg_trp cycles after the PRECHARGE, and READ follows exactly cfg_trcd cycles after the ACTIVATE. ACTIVATE never comes sooner than cfg_trp cycles after a PRECHARGE, and READ never comes sooner than cfg_trcd cycles after an ACTIVATE.
- R5: req_ready is low from the PRECHARGE or ACTIVATE of a miss until the third cycle after its READ. It is also low for three cycles after every READ. A request held valid is therefore accepted exactly three cycles after the previous READ, and READs are always at least four cycles apart.
- R6: data_valid is high in exactly the cycles cfg_cl to cfg_cl+3 after each READ, and low in every other cycle. Back-to-back same-row reads give one unbroken data_valid run.
- R7: If a miss request is held valid from the cycle after the previous READ, the data bus stays idle for exactly cfg_trp + cfg_trcd cycles between the two bursts, whatever cfg_cl is.
- R8: The cmd encoding is 00 NOP, 01 ACTIVATE, 10 READ, 11 PRECHARGE. cmd_row and cmd_col are valid on the command's cycle. cmd_col is zero for ACTIVATE and PRECHARGE, and both are zero on NOP.
- R9: cfg_cl, cfg_trp and cfg_trcd are runtime inputs that each accept 1 to 7. Changing them while the block is idle sets the timing for all later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cl | input | 3 | CAS latency in cycles (1..7) |
| cfg_trp | input | 3 | PRECHARGE-to-ACTIVATE delay in cycles (1..7) |
| cfg_trcd | input | 3 | ACTIVATE-to-READ delay in cycles (1..7) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_row | input | 13 | Row address of the request |
| req_col | input | 10 | Column address of the request |
| cmd | output | 2 | Command of this cycle (00 NOP, 01 ACT, 10 READ, 11 PRE) |
| cmd_row | output | 13 | Row accompanying the command |
| cmd_col | output | 10 | Column accompanying a READ |
| data_valid | output | 1 | High while burst data occupies the bus |

## Verification
Three timing sets are used: CL 2/tRP 2/tRCD 2, CL 3/tRP 4/tRCD 3 and CL 5/tRP 3/tRCD 4. Each set runs a lone read first, then a held stream of same-row reads with columns that jump up and down, then a held miss and a hit straight after it. The held stream separates correct early READ placement from placement that leaves a gap or lets bursts overlap. The held miss separates a correct close-and-reopen from one that cuts tRP or tRCD short or adds a stray cycle, and its idle count is compared against tRP + tRCD. Running the same pattern at several CAS latencies shows that the data-valid window moves with CL while the READ spacing stays fixed.

// File: rtl/rps_pkg.sv
// Package: shared command and sequencer-state types for the open-page
// read scheduler. Assumes a 2-bit command bus with the encoding below.
package rps_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_ACT = 2'b01,
        CMD_RD  = 2'b10,
        CMD_PRE = 2'b11
    } rps_cmd_e;

    typedef enum logic [1:0] {
        ST_RUN = 2'b00,   // page settled, requests may be taken
        ST_PRE = 2'b01,   // waiting out precharge-to-activate
        ST_ACT = 2'b10    // waiting out activate-to-read
    } rps_state_e;
endpackage

// File: rtl/rps_row_tracker.sv
// Row tracker: keeps the open row of the single bank and flags page hits.
// Assumes it sees every issued command one cycle after it is driven.
module rps_row_tracker
    import rps_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rps_cmd_e         cmd_i,
    input  logic [ROW_W-1:0] cmd_row_i,
    input  logic [ROW_W-1:0] req_row_i,
    output logic             row_open_o,
    output logic [ROW_W-1:0] open_row_o,
    output logic             req_hit_o
);
    logic             open_vld_q;
    logic [ROW_W-1:0] open_row_q;

    // Record the row opened by ACTIVATE and forget it on PRECHARGE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld_q <= 1'b0;
            open_row_q <= '0;
        end else if (cmd_i == CMD_ACT) begin
            open_vld_q <= 1'b1;
            open_row_q <= cmd_row_i;
        end else if (cmd_i == CMD_PRE) begin
            open_vld_q <= 1'b0;
        end
    end

    // Compare the incoming row with the open one.
    always_comb begin
        req_hit_o = open_vld_q && (req_row_i == open_row_q);
    end

    assign row_open_o = open_vld_q;
    assign open_row_o = open_row_q;

    AST_READ_IN_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_RD) |-> (open_vld_q && cmd_row_i == open_row_q)); // R3
endmodule

// File: rtl/rps_cmd_fsm.sv
// Command sequencer: accepts one request at a time and emits READ for a hit,
// PRE/ACT/READ for a miss, ACT/READ when no row is open. Holds READs four
// cycles apart so that the next burst abuts the current one. Assumes the
// timing inputs are at least 1 and stay fixed while a request is in flight.
module rps_cmd_fsm
    import rps_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int TW    = 3,
    parameter int BC    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    cfg_trp,
    input  logic [TW-1:0]    cfg_trcd,
    input  logic             req_fire,
    input  logic             req_hit,
    input  logic             row_open,
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             accept_ok,
    output rps_cmd_e         cmd_o,
    output logic [ROW_W-1:0] cmd_row_o,
    output logic [COL_W-1:0] cmd_col_o
);
    localparam int AGW = $clog2(BC) + 1;
    localparam logic [AGW-1:0] AGE_SAT = AGW'(BC - 1);

    rps_state_e       state_q;
    logic [TW-1:0]    wcnt_q;
    logic [AGW-1:0]   rd_age_q;
    logic [ROW_W-1:0] lat_row_q;
    logic [COL_W-1:0] lat_col_q;
    rps_cmd_e         cmd_q;
    logic [ROW_W-1:0] cmd_row_q;
    logic [COL_W-1:0] cmd_col_q;

    // Take a request only in the settled state and once the early-read slot is reached.
    assign accept_ok = (state_q == ST_RUN) && (rd_age_q == AGE_SAT);

    // Sequence commands and count the precharge / activate waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            wcnt_q    <= '0;
            rd_age_q  <= AGE_SAT;
            lat_row_q <= '0;
            lat_col_q <= '0;
            cmd_q     <= CMD_NOP;
            cmd_row_q <= '0;
            cmd_col_q <= '0;
        end else begin
            cmd_q     <= CMD_NOP;
            cmd_row_q <= '0;
            cmd_col_q <= '0;
            if (rd_age_q != AGE_SAT) rd_age_q <= rd_age_q + AGW'(1);
            case (state_q)
                ST_RUN: begin
                    if (req_fire) begin
                        lat_row_q <= req_row;
                        lat_col_q <= req_col;
                        if (req_hit) begin
                            cmd_q     <= CMD_RD;
                            cmd_row_q <= req_row;
                            cmd_col_q <= req_col;
                            rd_age_q  <= '0;
                        end else if (row_open) begin
                            cmd_q     <= CMD_PRE;
                            cmd_row_q <= open_row;
                            wcnt_q    <= cfg_trp - TW'(1);
                            state_q   <= ST_PRE;
                        end else begin
                            cmd_q     <= CMD_ACT;
                            cmd_row_q <= req_row;
                            wcnt_q    <= cfg_trcd - TW'(1);
                            state_q   <= ST_ACT;
                        end
                    end
                end
                ST_PRE: begin
                    if (wcnt_q == '0) begin
                        cmd_q     <= CMD_ACT;
                        cmd_row_q <= lat_row_q;
                        wcnt_q    <= cfg_trcd - TW'(1);
                        state_q   <= ST_ACT;
                    end else begin
                        wcnt_q <= wcnt_q - TW'(1);
                    end
                end
                ST_ACT: begin
                    if (wcnt_q == '0) begin
                        cmd_q     <= CMD_RD;
                        cmd_row_q <= lat_row_q;
                        cmd_col_q <= lat_col_q;
                        rd_age_q  <= '0;
                        state_q   <= ST_RUN;
                    end else begin
                        wcnt_q <= wcnt_q - TW'(1);
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    assign cmd_o     = cmd_q;
    assign cmd_row_o = cmd_row_q;
    assign cmd_col_o = cmd_col_q;

    AST_BUSY_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE) |=> (cmd_q != CMD_RD)); // R4
endmodule

// File: rtl/rps_dv_sched.sv
// Data-valid scheduler: a shift window that marks, for each READ, the
// BC cycles starting CL cycles later. Overlapping windows merge, so
// abutting bursts give one continuous strobe. Assumes 1 <= CL <= 2**TW-1.
module rps_dv_sched
    import rps_pkg::*;
#(
    parameter int TW = 3,
    parameter int BC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cfg_cl,
    input  rps_cmd_e      cmd_i,
    output logic          data_valid_o
);
    localparam int SW = (1 << TW) - 1 + BC;
    localparam logic [SW-1:0] BURST_MASK = {{(SW-BC){1'b0}}, {BC{1'b1}}};

    logic [SW-1:0] win_q;

    // Shift the window each cycle and drop in a burst when READ is on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (cmd_i == CMD_RD) begin
            win_q <= (win_q >> 1) | (BURST_MASK << (cfg_cl - TW'(1)));
        end else begin
            win_q <= win_q >> 1;
        end
    end

    assign data_valid_o = win_q[0];

    AST_BURST_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid_o) |=> data_valid_o); // R6
endmodule

// File: rtl/open_page_rd_sched.sv
// Top: single-bank open-page read scheduler. Joins the row tracker, the
// command sequencer and the data-valid window; also holds the command-age
// counters that the timing assertions use. Assumes cfg_* change only while idle.
module open_page_rd_sched
    import rps_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int TW        = 3,
    parameter int BURST_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    cfg_cl,
    input  logic [TW-1:0]    cfg_trp,
    input  logic [TW-1:0]    cfg_trcd,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic [1:0]       cmd,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             data_valid
);
    localparam int BC = BURST_LEN / 2;
    localparam int CW = TW + 1;
    localparam logic [CW-1:0] AGE_MAX = '1;

    rps_cmd_e         cmd_e;
    logic             row_open;
    logic             req_hit;
    logic             accept_ok;
    logic [ROW_W-1:0] open_row;

    rps_row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_e), .cmd_row_i(cmd_row),
        .req_row_i(req_row), .row_open_o(row_open), .open_row_o(open_row),
        .req_hit_o(req_hit)
    );

    rps_cmd_fsm #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW), .BC(BC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd),
        .req_fire(req_valid && accept_ok), .req_hit(req_hit),
        .row_open(row_open), .open_row(open_row), .req_row(req_row),
        .req_col(req_col), .accept_ok(accept_ok), .cmd_o(cmd_e),
        .cmd_row_o(cmd_row), .cmd_col_o(cmd_col)
    );

    rps_dv_sched #(.TW(TW), .BC(BC)) u_dv (
        .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cmd_i(cmd_e),
        .data_valid_o(data_valid)
    );

    assign req_ready = accept_ok;
    assign cmd       = cmd_e;

    // Assertion support: cycles since the last PRE, ACT and READ, saturating.
    logic [CW-1:0] pre_age_q, act_age_q, rd_age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_age_q <= AGE_MAX;
            act_age_q <= AGE_MAX;
            rd_age_q  <= AGE_MAX;
        end else begin
            pre_age_q <= (cmd_e == CMD_PRE) ? CW'(1) :
                         (pre_age_q == AGE_MAX) ? AGE_MAX : pre_age_q + CW'(1);
            act_age_q <= (cmd_e == CMD_ACT) ? CW'(1) :
                         (act_age_q == AGE_MAX) ? AGE_MAX : act_age_q + CW'(1);
            rd_age_q  <= (cmd_e == CMD_RD) ? CW'(1) :
                         (rd_age_q == AGE_MAX) ? AGE_MAX : rd_age_q + CW'(1);
        end
    end

    AST_TRP_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_ACT) |-> (pre_age_q >= CW'(cfg_trp))); // R4
    AST_TRCD_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_RD) |-> (act_age_q >= CW'(cfg_trcd))); // R4
    AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_RD) |-> (rd_age_q >= CW'(BC))); // R5
    AST_HIT_GOES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_hit) |=> (cmd_e == CMD_RD && cmd_col == $past(req_col))); // R3
    AST_PRE_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_PRE) |-> row_open); // R2
    AST_NO_TAKE_IN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_PRE || cmd_e == CMD_ACT) |-> !req_ready); // R5
endmodule

// File: tb/open_page_rd_sched_test.sv
module open_page_rd_sched_test;
    localparam int ROW_W = 13;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cfg_cl = 3'd2, cfg_trp = 3'd2, cfg_trcd = 3'd2;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [1:0]       cmd;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic             data_valid;

    open_page_rd_sched uut (
        .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_trp(cfg_trp),
        .cfg_trcd(cfg_trcd), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .cmd(cmd), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .data_valid(data_valid)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    typedef struct {
        int               cyc;
        logic [1:0]       c;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } exp_t;

    exp_t exp_q[$];
    bit   exp_dv[256];
    int   cyc = 0;
    int   n_chk = 0, n_bad = 0;
    bit   mon_on = 0;
    int   last_rd = -100;
    bit   m_open = 0;
    logic [ROW_W-1:0] m_row = '0;
    int   rises = 0, fall_cyc = 0, last_idle = -1;
    bit   seen_fall = 0;
    bit   prev_dv = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", rq, what, act, expv, cyc);
        end
    endtask

    task automatic push(input int c, input logic [1:0] k,
                        input logic [ROW_W-1:0] r, input logic [COL_W-1:0] col);
        exp_t e;
        e.cyc = c; e.c = k; e.row = r; e.col = col;
        exp_q.push_back(e);
    endtask

    task automatic mark_read(input int r);
        for (int i = 0; i < 4; i++) exp_dv[(r + int'(cfg_cl) + i) % 256] = 1'b1;
        last_rd = r;
    endtask

    // Driver: present one request, predict acceptance and every resulting command.
    task automatic send(input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col);
        int s, pred, a, rd;
        @(negedge clk);
        req_valid = 1'b1; req_row = row; req_col = col;
        s = cyc;
        pred = (s > last_rd + 3) ? s : last_rd + 3;
        while (!req_ready) @(negedge clk);
        a = cyc;
        chk(a == pred, "R5", "accept cycle", a, pred);
        if (m_open && row == m_row) begin            // R3 hit
            rd = a + 1;
            push(rd, 2'b10, row, col);
        end else if (m_open) begin                   // R4 miss
            push(a + 1, 2'b11, m_row, '0);
            push(a + 1 + int'(cfg_trp), 2'b01, row, '0);
            rd = a + 1 + int'(cfg_trp) + int'(cfg_trcd);
            push(rd, 2'b10, row, col);
        end else begin                               // R2 first access
            push(a + 1, 2'b01, row, '0);
            rd = a + 1 + int'(cfg_trcd);
            push(rd, 2'b10, row, col);
        end
        m_open = 1'b1; m_row = row;
        mark_read(rd);
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop expected commands, compare data_valid each cycle, measure idle runs.
    always @(negedge clk) begin
        if (mon_on) begin
            if (cmd != 2'b00) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected command", int'(cmd), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cmd == e.c, (e.c == 2'b10) ? "R3" : "R4", "command code", int'(cmd), int'(e.c));
                    chk(cyc == e.cyc, (e.c == 2'b01) ? "R2" : "R4", "command cycle", cyc, e.cyc);
                    chk(cmd_row == e.row, "R8", "command row", int'(cmd_row), int'(e.row));
                    chk(cmd_col == e.col, "R8", "command column", int'(cmd_col), int'(e.col));
                end
            end else begin
                chk(cmd_row == '0 && cmd_col == '0, "R8", "NOP address", int'(cmd_row), 0);
            end
            chk(data_valid == exp_dv[cyc % 256], "R6", "data_valid", int'(data_valid), int'(exp_dv[cyc % 256]));
            exp_dv[cyc % 256] = 1'b0;
            if (data_valid && !prev_dv) begin
                rises++;
                if (seen_fall) last_idle = cyc - fall_cyc;
            end
            if (!data_valid && prev_dv) begin
                fall_cyc = cyc;
                seen_fall = 1'b1;
            end
            prev_dv = data_valid;
        end
    end

    // One timing set: lone read, held hit stream, held miss, trailing hit.
    task automatic run_phase(input int cl, input int trp, input int trcd,
                             input logic [ROW_W-1:0] r);
        int r0;
        @(negedge clk);
        cfg_cl = 3'(cl); cfg_trp = 3'(trp); cfg_trcd = 3'(trcd);   // R9
        send(r, 10'd0);
        idle(20);
        r0 = rises;
        send(r, 10'd12);    // ascending then descending columns
        send(r, 10'd700);
        send(r, 10'd4);
        send(r, 10'd1);
        send(r + 13'd1, 10'd33);
        send(r + 13'd1, 10'd5);
        idle(30);
        chk(rises - r0 == 2, "R6", "burst runs in hit stream plus miss", rises - r0, 2);
        chk(last_idle == trp + trcd, "R7", "idle cycles across miss", last_idle, trp + trcd);
        send(r + 13'd1, 10'd9);   // late hit after idle
        idle(25);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd == 2'b00 && data_valid == 1'b0, "R1", "reset outputs", int'({cmd, data_valid}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(cmd == 2'b00 && cmd_row == '0 && cmd_col == '0, "R1", "idle command", int'(cmd), 0);
        mon_on = 1'b1;
        run_phase(2, 2, 2, 13'd5);
        run_phase(3, 4, 3, 13'd300);
        run_phase(5, 3, 4, 13'd4000);
        chk(exp_q.size() == 0, "R4", "outstanding expected commands", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R5 watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule